// File: doc/BRIEF.md
# Scanline polygon edge stepper

This block walks the two sloped edges of a filled triangle down the screen, one scanline at a time, so that a CPU drawing the triangle only has to write pixels. Each edge is held as a fixed-point position with an 11-bit pixel part and a 9-bit subpixel part. Each edge also has a signed step with 6 integer and 9 fractional bits, and a flag that scales the step by 32. Software loads the positions and steps through byte-wide register writes. After that, every read strobe on either data port moves both edges by one step. Two strobes make one scanline, so software loads half of the per-line slope.

A read on the secondary port also captures a span for the line that follows. The span start address is the line base address plus the left edge pixel. The span fill length is the right edge pixel minus the left edge pixel, and a flag marks a span that must be skipped because its length is negative. The line base address moves down one line on each primary-port read. It moves by 320 in 8-bit pixel mode and by 160 in 4-bit pixel mode. In 4-bit mode the span address also resolves to a nibble.

Top module: `poly_edge_stepper`

## Requirements
- R1: After a synchronous active-low reset, all positions, steps and the base address are zero. The outputs span_addr, span_nib, fill_len, len_hi and span_neg are all zero.
- R2: An edge step is a 15-bit two's-complement value {hi[6:1], hi[0], lo[7:0]} with 9 fractional bits. Bit 7 of the high byte scales the step by 32, which is a left shift by 5. Positions wrap modulo 2^20.
- R3: Writing an edge's high step byte sets that edge's 9 fractional position bits to 0x100, which is half a pixel.
- R4: Writing a position low byte loads pixel bits 7:0. Writing a position high byte loads pixel bits 10:8 from data bits 2:0 and the lowest fractional bit from data bit 7. All other position bits keep their value.
- R5: A secondary read adds each edge's step to its position. On the next clock edge, in 8-bit mode, span_addr becomes the base plus the stepped left pixel, modulo 2^17, and span_nib becomes 0.
- R6: A primary read steps both edges the same way and advances the base by 320 (8-bit mode) or 160 (4-bit mode). The span outputs keep their value.
- R7: On a secondary read, fill_len becomes (right pixel − left pixel) modulo 1024, using the stepped positions, and len_hi becomes {fill_len[9:3], 1'b0}.
- R8: span_neg is 1 exactly when bits 9 and 8 of fill_len are both 1.
- R9: In 4-bit mode (nibble_mode=1) a secondary read sets span_addr to the base plus the left pixel shifted right by one, and span_nib to bit 0 of the left pixel.
- R10: When both read strobes are high in the same cycle, the edges step once, the span is captured, and the base does not advance.
- R11: A register write in the same cycle as a read strobe is applied and the read is ignored: no step, no span capture, no base advance.
- R12: base_load loads base_data into the base. It takes priority over the advance from a primary read, and it is applied even when a write is in progress.
- R13: span_addr, span_nib, fill_len and span_neg change only on the clock edge after an accepted secondary read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nibble_mode | input | 1 | 1 selects 4-bit pixels, 0 selects 8-bit pixels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0/1 left step low/high, 2/3 right step low/high, 4/5 left position low/high, 6/7 right position low/high |
| wr_data | input | 8 | Register write data |
| base_load | input | 1 | Load the line base address |
| base_data | input | 17 | Value loaded into the line base address |
| rd_primary | input | 1 | Primary data port read strobe |
| rd_secondary | input | 1 | Secondary data port read strobe |
| span_addr | output | 17 | Span start address |
| span_nib | output | 1 | Nibble select of the span start in 4-bit mode |
| fill_len | output | 10 | Span fill length, two's complement |
| len_hi | output | 8 | Fill length bits 9:3 with bit 0 zero |
| span_neg | output | 1 | Negative span, do not draw |

## Verification
Directed scanlines use whole-pixel steps, scaled subpixel steps and crossed edges. Each one separates the half-pixel preset, the ×32 scaling and the negative-length flag from the plain subtraction. Seeded random sequences mix register writes, single and dual read strobes, base loads and mode changes. These sequences expose any disagreement in how a step accumulates carries across many lines, and in how colliding strobes and writes are prioritised. A run in 4-bit mode, set against 8-bit mode, shows whether the address halving, the nibble select and the 160-byte line advance are each applied.

// File: rtl/poly_edge_pkg.sv
// Package: shared widths and write-select codes of the scanline edge stepper.
// Assumes byte-wide register writes; the byte mapping of steps and positions
// relies on the default widths below.
package poly_edge_pkg;
    localparam int PIX_W      = 11;   // integer pixel bits of a position
    localparam int SUB_W      = 9;    // fractional bits of positions and steps
    localparam int STEP_INT_W = 6;    // integer bits of a step
    localparam int SCALE_SH   = 5;    // shift applied by the x32 flag
    localparam int LEN_W      = 10;   // fill length width
    localparam int ADDR_W     = 17;   // address width
    localparam int LINE_PIX   = 320;  // bytes per line in 8-bit mode

    localparam logic [2:0] SEL_L_STEP_LO = 3'd0;
    localparam logic [2:0] SEL_L_STEP_HI = 3'd1;
    localparam logic [2:0] SEL_R_STEP_LO = 3'd2;
    localparam logic [2:0] SEL_R_STEP_HI = 3'd3;
    localparam logic [2:0] SEL_L_POS_LO  = 3'd4;
    localparam logic [2:0] SEL_L_POS_HI  = 3'd5;
    localparam logic [2:0] SEL_R_POS_LO  = 3'd6;
    localparam logic [2:0] SEL_R_POS_HI  = 3'd7;

    // One-bit strobes that drive a single edge accumulator.
    typedef struct packed {
        logic step_lo;
        logic step_hi;
        logic pos_lo;
        logic pos_hi;
    } edge_wr_t;
endpackage

// File: rtl/poly_edge_accum.sv
// Module: one edge accumulator of the scanline stepper.
// Holds the byte-wide step registers and the fixed-point position, applies
// register writes, and adds the (optionally x32) step when step_en is high.
// Assumes the write strobes and step_en are never high together (the top
// gates stepping off during writes).
module poly_edge_accum
    import poly_edge_pkg::*;
#(
    parameter int P_PIX_W      = PIX_W,
    parameter int P_SUB_W      = SUB_W,
    parameter int P_STEP_INT_W = STEP_INT_W,
    parameter int P_SCALE_SH   = SCALE_SH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  edge_wr_t                     wr,
    input  logic [7:0]                   wr_data,
    input  logic                         step_en,
    output logic [P_PIX_W+P_SUB_W-1:0]   pos_q,
    output logic [P_PIX_W-1:0]           pix_next
);
    localparam int POS_W  = P_PIX_W + P_SUB_W;
    localparam int STEP_W = P_STEP_INT_W + P_SUB_W;
    localparam int HI_PIX = P_PIX_W - 8;
    localparam logic [P_SUB_W-1:0] HALF_PIX = P_SUB_W'(1) << (P_SUB_W - 1);

    logic [7:0]        step_lo_q;
    logic [7:0]        step_hi_q;
    logic [STEP_W-1:0] step_raw;
    logic [POS_W-1:0]  step_ext;
    logic [POS_W-1:0]  step_val;
    logic [POS_W-1:0]  pos_next;

    // Step register bytes: written directly, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_lo_q <= '0;
            step_hi_q <= '0;
        end else begin
            if (wr.step_lo) step_lo_q <= wr_data;
            if (wr.step_hi) step_hi_q <= wr_data;
        end
    end

    // Assemble the signed step, sign-extend it and apply the x32 scaling.
    always_comb begin
        step_raw = {step_hi_q[P_STEP_INT_W:0], step_lo_q};
        step_ext = {{(POS_W-STEP_W){step_raw[STEP_W-1]}}, step_raw};
        step_val = step_hi_q[7] ? (step_ext << P_SCALE_SH) : step_ext;
        pos_next = pos_q + step_val;
        pix_next = pos_next[POS_W-1:P_SUB_W];
    end

    // Position register: byte writes, half-pixel preset, or one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (wr.pos_lo) begin
            pos_q[P_SUB_W +: 8] <= wr_data;
        end else if (wr.pos_hi) begin
            pos_q[POS_W-1 -: HI_PIX] <= wr_data[HI_PIX-1:0];
            pos_q[0]                 <= wr_data[7];
        end else if (wr.step_hi) begin
            pos_q[P_SUB_W-1:0] <= HALF_PIX;
        end else if (step_en) begin
            pos_q <= pos_next;
        end
    end
endmodule

// File: rtl/poly_line_base.sv
// Module: line base address register of the scanline stepper.
// Loads from outside or moves down one line per advance pulse; the line
// pitch is halved in 4-bit pixel mode. A load wins over an advance.
module poly_line_base
    import poly_edge_pkg::*;
#(
    parameter int P_ADDR_W   = ADDR_W,
    parameter int P_LINE_PIX = LINE_PIX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nibble_mode,
    input  logic                load,
    input  logic [P_ADDR_W-1:0] load_val,
    input  logic                advance,
    output logic [P_ADDR_W-1:0] base_q
);
    localparam logic [P_ADDR_W-1:0] PITCH_8 = P_ADDR_W'(P_LINE_PIX);
    localparam logic [P_ADDR_W-1:0] PITCH_4 = P_ADDR_W'(P_LINE_PIX / 2);

    logic [P_ADDR_W-1:0] pitch;

    // Pick the line pitch for the current pixel depth.
    always_comb pitch = nibble_mode ? PITCH_4 : PITCH_8;

    // Base register: reset, load, or advance one line.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (load)    base_q <= load_val;
        else if (advance) base_q <= base_q + pitch;
    end
endmodule

// File: rtl/poly_span_calc.sv
// Module: span capture of the scanline stepper.
// On capture, registers the span start address (byte or nibble resolved),
// the two's-complement fill length and the negative-span marker from the
// stepped edge pixels. Outputs hold between captures.
module poly_span_calc
    import poly_edge_pkg::*;
#(
    parameter int P_PIX_W  = PIX_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_LEN_W  = LEN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                nibble_mode,
    input  logic [P_ADDR_W-1:0] base,
    input  logic [P_PIX_W-1:0]  left_pix,
    input  logic [P_PIX_W-1:0]  right_pix,
    output logic [P_ADDR_W-1:0] span_addr,
    output logic                span_nib,
    output logic [P_LEN_W-1:0]  fill_len,
    output logic                span_neg
);
    logic [P_PIX_W-1:0]  offset;
    logic [P_PIX_W-1:0]  diff;
    logic [P_ADDR_W-1:0] addr_d;

    // Span start offset and raw edge difference.
    always_comb begin
        offset = nibble_mode ? (left_pix >> 1) : left_pix;
        addr_d = base + P_ADDR_W'(offset);
        diff   = right_pix - left_pix;
    end

    // Span registers: captured on an accepted secondary read only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_addr <= '0;
            span_nib  <= 1'b0;
            fill_len  <= '0;
            span_neg  <= 1'b0;
        end else if (capture) begin
            span_addr <= addr_d;
            span_nib  <= nibble_mode & left_pix[0];
            fill_len  <= diff[P_LEN_W-1:0];
            span_neg  <= diff[P_LEN_W-1] & diff[P_LEN_W-2];
        end
    end
endmodule

// File: rtl/poly_edge_stepper.sv
// Module: scanline polygon edge stepper (top).
// Two edge accumulators step on every accepted data-port read; a secondary
// read also captures the span of the next line, a primary read moves the
// line base. A register write in the same cycle as a read cancels the read.
module poly_edge_stepper
    import poly_edge_pkg::*;
#(
    parameter int P_PIX_W      = PIX_W,
    parameter int P_SUB_W      = SUB_W,
    parameter int P_STEP_INT_W = STEP_INT_W,
    parameter int P_SCALE_SH   = SCALE_SH,
    parameter int P_LEN_W      = LEN_W,
    parameter int P_ADDR_W     = ADDR_W,
    parameter int P_LINE_PIX   = LINE_PIX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nibble_mode,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [7:0]          wr_data,
    input  logic                base_load,
    input  logic [P_ADDR_W-1:0] base_data,
    input  logic                rd_primary,
    input  logic                rd_secondary,
    output logic [P_ADDR_W-1:0] span_addr,
    output logic                span_nib,
    output logic [P_LEN_W-1:0]  fill_len,
    output logic [7:0]          len_hi,
    output logic                span_neg
);
    localparam int POS_W    = P_PIX_W + P_SUB_W;
    localparam int N_EDGES  = 2;

    logic                step_go;
    logic                capture_go;
    logic                advance_go;
    logic [P_ADDR_W-1:0] base_q;
    logic [POS_W-1:0]    pos_q    [N_EDGES];
    logic [P_PIX_W-1:0]  pix_next [N_EDGES];
    logic [POS_W-1:0]    left_pos;
    logic [POS_W-1:0]    right_pos;

    // Read acceptance: writes cancel reads; a dual strobe acts as secondary.
    always_comb begin
        step_go    = (rd_primary | rd_secondary) & ~wr_en;
        capture_go = rd_secondary & ~wr_en;
        advance_go = rd_primary & ~rd_secondary & ~wr_en;
    end

    // One accumulator per edge; edge 0 is left, edge 1 is right.
    for (genvar e = 0; e < N_EDGES; e++) begin : g_edge
        localparam logic [2:0] C_STEP_LO = 3'(2 * e);
        localparam logic [2:0] C_STEP_HI = 3'(2 * e + 1);
        localparam logic [2:0] C_POS_LO  = 3'(4 + 2 * e);
        localparam logic [2:0] C_POS_HI  = 3'(5 + 2 * e);
        edge_wr_t wr_e;

        // Decode the write select into this edge's strobes.
        always_comb begin
            wr_e.step_lo = wr_en & (wr_sel == C_STEP_LO);
            wr_e.step_hi = wr_en & (wr_sel == C_STEP_HI);
            wr_e.pos_lo  = wr_en & (wr_sel == C_POS_LO);
            wr_e.pos_hi  = wr_en & (wr_sel == C_POS_HI);
        end

        poly_edge_accum #(
            .P_PIX_W      (P_PIX_W),
            .P_SUB_W      (P_SUB_W),
            .P_STEP_INT_W (P_STEP_INT_W),
            .P_SCALE_SH   (P_SCALE_SH)
        ) u_accum (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_e),
            .wr_data  (wr_data),
            .step_en  (step_go),
            .pos_q    (pos_q[e]),
            .pix_next (pix_next[e])
        );
    end

    // Named views of the two edge positions.
    always_comb begin
        left_pos  = pos_q[0];
        right_pos = pos_q[1];
    end

    poly_line_base #(
        .P_ADDR_W   (P_ADDR_W),
        .P_LINE_PIX (P_LINE_PIX)
    ) u_base (
        .clk         (clk),
        .rst_n       (rst_n),
        .nibble_mode (nibble_mode),
        .load        (base_load),
        .load_val    (base_data),
        .advance     (advance_go),
        .base_q      (base_q)
    );

    poly_span_calc #(
        .P_PIX_W  (P_PIX_W),
        .P_ADDR_W (P_ADDR_W),
        .P_LEN_W  (P_LEN_W)
    ) u_span (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture_go),
        .nibble_mode (nibble_mode),
        .base        (base_q),
        .left_pix    (pix_next[0]),
        .right_pix   (pix_next[1]),
        .span_addr   (span_addr),
        .span_nib    (span_nib),
        .fill_len    (fill_len),
        .span_neg    (span_neg)
    );

    // High length read byte: length bits 9:3 above a zero bit.
    always_comb len_hi = {fill_len[P_LEN_W-1:3], 1'b0};
endmodule

// File: rtl/poly_edge_stepper_chk.sv
// Module: assertion checker for the scanline edge stepper, bound to the top.
// Observes ports and the edge/base state; all properties are reset-gated.
module poly_edge_stepper_chk
    import poly_edge_pkg::*;
#(
    parameter int P_PIX_W    = PIX_W,
    parameter int P_SUB_W    = SUB_W,
    parameter int P_LEN_W    = LEN_W,
    parameter int P_ADDR_W   = ADDR_W,
    parameter int P_LINE_PIX = LINE_PIX
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         nibble_mode,
    input logic                         wr_en,
    input logic [2:0]                   wr_sel,
    input logic                         base_load,
    input logic                         rd_primary,
    input logic                         rd_secondary,
    input logic [P_ADDR_W-1:0]          base_q,
    input logic [P_PIX_W+P_SUB_W-1:0]   left_pos,
    input logic [P_PIX_W+P_SUB_W-1:0]   right_pos,
    input logic [P_ADDR_W-1:0]          span_addr,
    input logic [P_LEN_W-1:0]           fill_len,
    input logic                         span_neg
);
    localparam int POS_W = P_PIX_W + P_SUB_W;
    localparam logic [P_SUB_W-1:0] HALF_PIX = P_SUB_W'(1) << (P_SUB_W - 1);

    AST_HALF_PIX_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_L_STEP_HI) |=> left_pos[P_SUB_W-1:0] == HALF_PIX); // R3

    AST_SPAN_ADDR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_secondary && !wr_en && !nibble_mode)
        |=> span_addr == $past(base_q) + P_ADDR_W'(left_pos[POS_W-1:P_SUB_W])); // R5

    AST_BASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_primary && !rd_secondary && !wr_en && !base_load)
        |=> base_q == $past(base_q) + ($past(nibble_mode) ? P_ADDR_W'(P_LINE_PIX / 2)
                                                           : P_ADDR_W'(P_LINE_PIX))); // R6

    AST_FILL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_secondary && !wr_en)
        |=> fill_len == P_LEN_W'(right_pos[POS_W-1:P_SUB_W] - left_pos[POS_W-1:P_SUB_W])); // R7

    AST_NEG_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        span_neg == (fill_len[P_LEN_W-1] && fill_len[P_LEN_W-2])); // R8

    AST_WRITE_CANCELS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_L_STEP_LO)
        |=> $stable(left_pos) && $stable(right_pos)); // R11

    AST_SPAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_secondary && !wr_en) |=> $stable(span_addr) && $stable(fill_len)); // R13
endmodule

bind poly_edge_stepper poly_edge_stepper_chk #(
    .P_PIX_W    (P_PIX_W),
    .P_SUB_W    (P_SUB_W),
    .P_LEN_W    (P_LEN_W),
    .P_ADDR_W   (P_ADDR_W),
    .P_LINE_PIX (P_LINE_PIX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .nibble_mode  (nibble_mode),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .base_load    (base_load),
    .rd_primary   (rd_primary),
    .rd_secondary (rd_secondary),
    .base_q       (base_q),
    .left_pos     (left_pos),
    .right_pos    (right_pos),
    .span_addr    (span_addr),
    .fill_len     (fill_len),
    .span_neg     (span_neg)
);

// File: tb/poly_edge_stepper_bench.sv
// Bench: seeded random plus directed scanline cases against a bench model.
module poly_edge_stepper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nibble_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        base_load = 1'b0;
    logic [16:0] base_data = '0;
    logic        rd_primary = 1'b0;
    logic        rd_secondary = 1'b0;
    logic [16:0] span_addr;
    logic        span_nib;
    logic [9:0]  fill_len;
    logic [7:0]  len_hi;
    logic        span_neg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state.
    logic [19:0] m_pos [2];
    logic [7:0]  m_slo [2];
    logic [7:0]  m_shi [2];
    logic [16:0] m_base;
    logic [16:0] m_addr;
    logic        m_nib;
    logic [9:0]  m_len;

    always #2 clk = ~clk;

    poly_edge_stepper u_poly_edge_stepper (
        .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .base_load(base_load), .base_data(base_data),
        .rd_primary(rd_primary), .rd_secondary(rd_secondary),
        .span_addr(span_addr), .span_nib(span_nib), .fill_len(fill_len),
        .len_hi(len_hi), .span_neg(span_neg)
    );

    // R2: value of a step from its two bytes, as a 20-bit addend.
    function automatic logic [19:0] step_of(input logic [7:0] lo, input logic [7:0] hi);
        logic signed [14:0] raw;
        logic signed [19:0] v;
        raw = {hi[6:0], lo};
        v = 20'(raw);
        if (hi[7]) v = v * 32;
        return v;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [9:0] e_hi;
        e_hi = {m_len[9:3], 1'b0};
        chk(req, "span_addr", 32'(span_addr), 32'(m_addr));
        chk(req, "span_nib", 32'(span_nib), 32'(m_nib));
        chk(req, "fill_len", 32'(fill_len), 32'(m_len));
        chk(req, "len_hi", 32'(len_hi), 32'(e_hi[7:0]));
        chk(req, "span_neg R8", 32'(span_neg), 32'(m_len[9] & m_len[8]));
    endtask

    // Model of one cycle with the given inputs (R2-R12).
    task automatic model_step(input logic we, input logic [2:0] sel, input logic [7:0] d,
                              input logic rp, input logic rs, input logic bl, input logic [16:0] bd);
        int e;
        logic [10:0] lp;
        logic [10:0] rpx;
        if (we) begin
            e = int'(sel[1]);
            case ({sel[2], sel[0]})
                2'b00: m_slo[e] = d;
                2'b01: begin m_shi[e] = d; m_pos[e][8:0] = 9'h100; end      // R3
                2'b10: m_pos[e][16:9] = d;                                   // R4
                default: begin m_pos[e][19:17] = d[2:0]; m_pos[e][0] = d[7]; end
            endcase
        end else if (rp || rs) begin
            for (int k = 0; k < 2; k++) m_pos[k] = m_pos[k] + step_of(m_slo[k], m_shi[k]);
            if (rs) begin
                lp  = m_pos[0][19:9];
                rpx = m_pos[1][19:9];
                m_addr = m_base + 17'(nibble_mode ? lp / 2 : lp);
                m_nib  = nibble_mode & lp[0];
                m_len  = 10'(rpx - lp);
            end
        end
        if (bl) m_base = bd;
        else if (rp && !rs && !we) m_base = m_base + (nibble_mode ? 17'd160 : 17'd320);
    endtask

    task automatic op(input logic we, input logic [2:0] sel, input logic [7:0] d,
                      input logic rp, input logic rs, input logic bl, input logic [16:0] bd);
        wr_en = we; wr_sel = sel; wr_data = d;
        rd_primary = rp; rd_secondary = rs; base_load = bl; base_data = bd;
        @(posedge clk);
        model_step(we, sel, d, rp, rs, bl, bd);
        #1;
        wr_en = 1'b0; rd_primary = 1'b0; rd_secondary = 1'b0; base_load = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        op(1'b1, sel, d, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic set_pos(input int e, input logic [10:0] px);
        wr(3'(4 + 2 * e), px[7:0]);
        wr(3'(5 + 2 * e), {5'b0, px[10:8]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 2; k++) begin m_pos[k] = '0; m_slo[k] = '0; m_shi[k] = '0; end
        m_base = '0; m_addr = '0; m_nib = 1'b0; m_len = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1");

        // R2/R3/R5/R7: left step +1.0, right step 1/512 scaled x32.
        wr(3'd0, 8'h00); wr(3'd1, 8'h02);
        wr(3'd2, 8'h01); wr(3'd3, 8'h80);
        set_pos(0, 11'd10); set_pos(1, 11'd50);
        op(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 17'd1000);
        op(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
        check_all("R5 R7 R2");
        // R4: high position byte with lowest fractional bit.
        wr(3'd5, 8'h81);
        op(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
        check_all("R4");
        // R6: primary read holds span, moves base.
        op(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, '0);
        check_all("R6 R13");
        op(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
        check_all("R6");
        // R8: crossed edges give a negative span.
        set_pos(0, 11'd100); set_pos(1, 11'd20);
        op(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
        check_all("R8");
        chk("R8", "neg set", 32'(span_neg), 32'd1);
        // R9: 4-bit mode nibble span and half pitch.
        nibble_mode = 1'b1;
        set_pos(0, 11'd37); set_pos(1, 11'd90);
        op(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, '0);
        op(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
        check_all("R9");
        nibble_mode = 1'b0;
        // R10: both strobes together.
        op(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 1'b0, '0);
        check_all("R10");
        op(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
        check_all("R10");
        // R11: write with a read cancels the read.
        op(1'b1, 3'd0, 8'h40, 1'b1, 1'b1, 1'b0, '0);
        check_all("R11");
        op(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
        check_all("R11");
        // R12: base load wins over primary advance.
        op(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 17'd5000);
        op(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
        check_all("R12");

        // Seeded random mix of writes, reads, loads and mode changes.
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 15) nibble_mode = $urandom % 2 == 1;
            if (r < 4)
                op(1'b1, 3'($urandom), 8'($urandom), $urandom % 4 == 0, $urandom % 4 == 0, 1'b0, '0);
            else if (r < 6)
                op(1'b0, 3'd0, 8'h00, $urandom % 2 == 1, 1'b0, 1'b1, 17'($urandom));
            else if (r < 10)
                op(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, '0);
            else if (r < 14)
                op(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
            else
                op(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 1'b0, '0);
            check_all("R13 R5 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule